// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt event of a real-time clock. A one-cycle `tick` strobe at 32.768 kHz drives a 15-bit prescaler. The 4-bit rate code and the divider control field of the first control register select one tap of that prescaler. The periodic enable bit of the second control register gates the block. When the selected period ends, the block emits a one-cycle event. The same event drives a mask that the surrounding register file ORs into its status register, and it raises the interrupt line.

The prescaler is held at zero whenever the generator is idle. The generator is idle when the rate code is zero, when the oscillator is off, or when the enable is low. A write to the first control register also clears the prescaler. Every start therefore runs one full period before the first event.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, and while reset is held, `evt` is 0 and `flag_set` is 0x00.
- R2: With `rate_sel` equal to 0, no event is produced.
- R3: For an effective code n between 3 and 15, an event follows every 2^(n-1) ticks. The first event comes 2^(n-1) ticks after the generator starts. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R4: Rate codes 1 and 2 give exactly the periods of codes 8 and 9, which are 128 and 256 ticks.
- R5: When `div_ctl[2:1]` is 00, the oscillator is off and no event occurs. `div_ctl[0]` has no effect on the period.
- R6: Events occur only while `periodic_en` is 1. Dropping it stops the generator. Raising it again with a nonzero rate starts a full new period.
- R7: A `cfg_wr` pulse clears the prescaler. The tick in the same cycle is not counted, and the next event comes one full period (at the current rate) after the write.
- R8: `evt` is high for exactly one clock, in the cycle after the clock edge that samples the period-completing tick. `flag_set` is 0xC0 (bits 7 and 6) during that cycle and 0x00 otherwise.
- R9: Only cycles with `tick` high advance the period; clock cycles without a tick do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_sel | input | 4 | Periodic rate code from control register A |
| div_ctl | input | 3 | Divider control field from control register A |
| periodic_en | input | 1 | Periodic interrupt enable from control register B |
| cfg_wr | input | 1 | Pulse marking a write to control register A |
| evt | output | 1 | One-cycle periodic event / interrupt raise |
| flag_set | output | 8 | Status register C set mask (0xC0 during an event) |

## Verification
An event is due one clock after the edge that samples the tick completing the period. That edge passes through one prescaler compare and one output register, so the bench model registers its own expectation on the same edge. The bench drives every input at the falling edge and compares `evt` and `flag_set` with the model at the next falling edge. The model counts ticks since the last restart and flags a multiple of the period, so the output is checked in every cycle, including at restarts caused by writes, enable changes and gating. Per-phase event counts add checks for the absence of events and for the single event of the longest period.

// File: rtl/rtc_pir_pkg.sv
package rtc_pir_pkg;
  localparam int RATE_W  = 4;
  localparam int DIVC_W  = 3;
  localparam int PRESC_W = 15;
  localparam int FLAG_W  = 8;

  // Fold the two short-period aliases onto their long equivalents.
  function automatic logic [RATE_W-1:0] fold_code(input logic [RATE_W-1:0] rs);
    logic [RATE_W-1:0] r;
    r = rs;
    if (rs == RATE_W'(1)) r = RATE_W'(8);
    if (rs == RATE_W'(2)) r = RATE_W'(9);
    return r;
  endfunction

  // Low-bit mask of the prescaler that must be all ones at period end.
  function automatic logic [PRESC_W-1:0] tap_mask(input logic [RATE_W-1:0] code);
    logic [PRESC_W-1:0] m;
    if (code == '0) m = '0;
    else            m = (PRESC_W'(1) << (code - RATE_W'(1))) - PRESC_W'(1);
    return m;
  endfunction
endpackage

// File: rtl/pir_rate_decode.sv
module pir_rate_decode
  import rtc_pir_pkg::*;
(
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic [DIVC_W-1:0]  div_ctl,
  input  logic               enable,
  output logic               run,
  output logic [PRESC_W-1:0] mask
);
  logic osc_on;
  logic rate_on;

  assign osc_on  = |div_ctl[DIVC_W-1:DIVC_W-2];
  assign rate_on = |rate_sel;
  assign run     = osc_on && rate_on && enable;
  assign mask    = tap_mask(fold_code(rate_sel));
endmodule

// File: rtl/pir_prescaler.sv
module pir_prescaler
  import rtc_pir_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  output logic [PRESC_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (tick)       cnt <= cnt + PRESC_W'(1);
  end

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt));

  // R7
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/pir_event.sv
module pir_event
  import rtc_pir_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               clear,
  input  logic [PRESC_W-1:0] cnt,
  input  logic [PRESC_W-1:0] mask,
  output logic               evt
);
  logic at_end;

  assign at_end = run && !clear && tick && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= at_end;
  end

  // R8
  evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(tick));
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_pir_pkg::*;
#(
  parameter logic [FLAG_W-1:0] FLAG_SET = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DIVC_W-1:0] div_ctl,
  input  logic              periodic_en,
  input  logic              cfg_wr,
  output logic              evt,
  output logic [FLAG_W-1:0] flag_set
);
  logic               run;
  logic               restart;
  logic [PRESC_W-1:0] mask;
  logic [PRESC_W-1:0] cnt;

  pir_rate_decode u_dec (
    .rate_sel (rate_sel),
    .div_ctl  (div_ctl),
    .enable   (periodic_en),
    .run      (run),
    .mask     (mask)
  );

  assign restart = cfg_wr || !run;

  pir_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .tick  (tick),
    .cnt   (cnt)
  );

  pir_event u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (run),
    .clear (restart),
    .cnt   (cnt),
    .mask  (mask),
    .evt   (evt)
  );

  assign flag_set = evt ? FLAG_SET : '0;

  // R8
  evt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  // R2
  rate_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel == '0) |-> !evt);

  // R5
  osc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_ctl[DIVC_W-1:DIVC_W-2] == 2'b00) |-> !evt);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!periodic_en) |-> !evt);

  // R7
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> !evt);
endmodule

// File: tb/test_rtc_periodic_gen.sv
module test_rtc_periodic_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_on = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_ctl = 3'b010;
  logic       periodic_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       evt;
  logic [7:0] flag_set;

  int    checks = 0;
  int    errors = 0;
  int    rticks = 0;
  bit    exp_evt = 1'b0;
  int    ev_cnt = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  rtc_periodic_gen i_rtc_periodic_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .periodic_en(periodic_en), .cfg_wr(cfg_wr),
    .evt(evt), .flag_set(flag_set)
  );

  function automatic int ref_period(input int r);
    int n;
    n = (r == 1 || r == 2) ? r + 7 : r;
    return 1 << (n - 1);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: ticks since the last restart, event on a period multiple.
  always @(posedge clk) begin
    if (!rst_n) begin
      rticks  <= 0;
      exp_evt <= 1'b0;
    end else if (cfg_wr || rate_sel == 0 || div_ctl[2:1] == 2'b00 || !periodic_en) begin
      rticks  <= 0;
      exp_evt <= 1'b0;
    end else if (tick) begin
      rticks  <= rticks + 1;
      exp_evt <= ((rticks + 1) % ref_period(int'(rate_sel))) == 0;
    end else begin
      exp_evt <= 1'b0;
    end
  end

  // Tick strobe every other cycle, plus the per-cycle output comparison.
  always @(negedge clk) begin
    if (!done) begin
      check_eq({cur_req, " R8 evt"}, int'(evt), int'(exp_evt));
      check_eq({cur_req, " R8 flag_set"}, int'(flag_set), exp_evt ? 32'hC0 : 0);
      if (evt) ev_cnt++;
    end
    tick <= tick_on && !tick;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input int r, input int d, input bit en);
    @(negedge clk);
    rate_sel = 4'(r); div_ctl = 3'(d); periodic_en = en;
  endtask

  task automatic write_a(input int r, input int d);
    @(negedge clk);
    rate_sel = 4'(r); div_ctl = 3'(d); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    // R1: reset state
    cur_req = "R1";
    cyc(4);
    check_eq("R1 evt in reset", int'(evt), 0);
    check_eq("R1 flag_set in reset", int'(flag_set), 0);
    rst_n = 1'b1;
    tick_on = 1'b1;
    cyc(3);
    check_eq("R1 evt after reset", int'(evt), 0);

    // R2: rate zero never fires
    cur_req = "R2";
    setup(0, 2, 1'b1);
    ev_cnt = 0; cyc(600);
    check_eq("R2 events with rate 0", ev_cnt, 0);

    // R3: shortest period, 4 ticks = 8 clocks
    cur_req = "R3";
    setup(3, 2, 1'b0); setup(3, 2, 1'b1);
    ev_cnt = 0; cyc(800);
    check_eq("R3 events code 3 in 400 ticks", ev_cnt, 100);

    // R3: longest period, 16384 ticks, one event in the window
    setup(15, 2, 1'b0); setup(15, 2, 1'b1);
    ev_cnt = 0; cyc(33000);
    check_eq("R3 events code 15", ev_cnt, 1);

    // R4: aliases against their long codes
    cur_req = "R4";
    setup(1, 2, 1'b0); setup(1, 2, 1'b1);
    ev_cnt = 0; cyc(1024);
    check_eq("R4 events code 1", ev_cnt, 4);
    setup(8, 2, 1'b0); setup(8, 2, 1'b1);
    ev_cnt = 0; cyc(1024);
    check_eq("R4 events code 8", ev_cnt, 4);
    setup(2, 2, 1'b0); setup(2, 2, 1'b1);
    ev_cnt = 0; cyc(1024);
    check_eq("R4 events code 2", ev_cnt, 2);

    // R5: oscillator off, then bit 0 ignored
    cur_req = "R5";
    setup(3, 0, 1'b1);
    ev_cnt = 0; cyc(400);
    check_eq("R5 events div 000", ev_cnt, 0);
    setup(3, 1, 1'b1);
    ev_cnt = 0; cyc(400);
    check_eq("R5 events div 001", ev_cnt, 0);
    setup(3, 3, 1'b0); setup(3, 3, 1'b1);
    ev_cnt = 0; cyc(800);
    check_eq("R5 events div 011", ev_cnt, 100);

    // R6: enable drop and restart mid-period
    cur_req = "R6";
    setup(5, 2, 1'b1); cyc(20);
    setup(5, 2, 1'b0);
    ev_cnt = 0; cyc(300);
    check_eq("R6 events while disabled", ev_cnt, 0);
    setup(5, 2, 1'b1); cyc(200);

    // R7: writes keep restarting the period
    cur_req = "R7";
    setup(6, 2, 1'b1);
    ev_cnt = 0;
    for (int k = 0; k < 6; k++) begin cyc(40); write_a(6, 2); end
    check_eq("R7 events with writes every 40 clocks", ev_cnt, 0);
    cyc(300);

    // R9: stopped ticks freeze the count
    cur_req = "R9";
    setup(3, 2, 1'b0); setup(3, 2, 1'b1);
    tick_on = 1'b0;
    ev_cnt = 0; cyc(300);
    check_eq("R9 events with no ticks", ev_cnt, 0);
    tick_on = 1'b1; cyc(200);

    // Random segments checked against the model every cycle
    cur_req = "R3 random";
    for (int s = 0; s < 40; s++) begin
      int r;
      r = int'($urandom_range(0, 10));
      setup(r, int'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0));
      for (int c = 0; c < 300; c++) begin
        if ($urandom_range(0, 99) == 0) write_a(int'($urandom_range(0, 10)), 2);
        else cyc(1);
      end
    end

    finish_run();
  end
endmodule